// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block decides which conversion a multi-channel sigma-delta converter performs next. Requests come from two places. Host software writes a channel and a current-source setting and pulses a request. A programmable period timer, running only while automatic mode is on, raises a periodic request for a second channel. When both are waiting, the software request goes first. The periodic request that lost stays pending and runs as soon as the software conversion ends.

For each granted request the block drives the channel-select bus and, for channel 0 only, the current-source code. It then counts a settling delay in clock cycles, optionally lengthened by a 400 µs extension, and pulses a one-cycle sample strobe. It waits for the converter's done pulse and latches the 12-bit code into the result register of the source that asked. It also sets a valid flag and a status bit, which drive a level interrupt. A request for a channel outside the usable set is never started. Instead it sets a sticky error bit and raises the interrupt with no new result.

Top module: `adc_req_seq`

## Requirements
- R1: When the sequencer is idle and both a software request and a periodic request are pending, the software request is granted first. The periodic request stays pending and is granted after the software conversion completes.
- R2: Only channels 0, 1, 2, 7, 10, 11, 12, 13 and 15 are started. A request for any other channel produces no sample strobe and no result. It sets status bit 2 and clears its own pending request.
- R3: A granted valid request pulses `adc_sample` high for exactly one cycle. The pulse comes D cycles after the grant edge, where D is BASE_CYC when `ext_delay` is 0 at grant time and BASE_CYC+EXT_CYC when it is 1. EXT_CYC is the cycle count of 400 µs at the clock frequency.
- R4: `adc_chan` shows the granted channel and holds it stable until the next grant. `adc_isrc` carries the requested current code only when that channel is 0 and is 0 otherwise. The codes 0, 1, 2 and 3 select 0, 5, 15 and 20 µA.
- R5: When `adc_done` arrives while the sequencer is waiting, `adc_data` (12-bit unsigned) is stored in `sw_result` or `auto_result`, depending on which source asked. The matching valid flag is set, and status bit 0 (software) or bit 1 (periodic) is set.
- R6: A pulse on `sw_rd` clears `sw_valid`, and a pulse on `auto_rd` clears `auto_valid`. A completion in the same cycle wins over the read.
- R7: Writing `status_wdata` with `status_wr` high clears each status bit written as 1, and a set in the same cycle wins. `irq` is high exactly while any status bit is set.
- R8: While `auto_en` is high, a periodic request is raised every `auto_period` cycles, with 0 treated as 1, and the periodic channel and current code are taken at grant time. While `auto_en` is low the period count is held at zero and no periodic request is raised.
- R9: An `adc_done` pulse while the sequencer is not waiting for a conversion changes no result, valid flag or status bit.
- R10: After reset all outputs are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | One-cycle software conversion request |
| sw_chan | input | 4 | Software channel, captured with `sw_req` |
| sw_isrc | input | 2 | Software current code, captured with `sw_req` |
| auto_en | input | 1 | Enables the period timer |
| auto_period | input | 16 | Period of automatic requests in cycles |
| auto_chan | input | 4 | Channel used for periodic conversions |
| auto_isrc | input | 2 | Current code for periodic conversions |
| ext_delay | input | 1 | Adds the 400 µs extension to the settling delay |
| sw_rd | input | 1 | Host read of the software result; clears its valid flag |
| auto_rd | input | 1 | Host read of the periodic result; clears its valid flag |
| status_wr | input | 1 | Write strobe for the clear-on-one status register |
| status_wdata | input | 3 | Bits to clear in the status register |
| adc_chan | output | 4 | Channel-select bus to the multiplexer |
| adc_isrc | output | 2 | Current-source select for channel 0 |
| adc_sample | output | 1 | One-cycle sample strobe to the converter |
| adc_done | input | 1 | Converter done pulse |
| adc_data | input | 12 | Converter result, valid with `adc_done` |
| sw_result | output | 12 | Last software conversion result |
| sw_valid | output | 1 | Software result not yet read |
| auto_result | output | 12 | Last periodic conversion result |
| auto_valid | output | 1 | Periodic result not yet read |
| status | output | 3 | Bit 0 software done, bit 1 periodic done, bit 2 channel error |
| irq | output | 1 | Level interrupt, OR of the status bits |

## Verification
A wrong arbitration or pending state shows at once in the order of channels on `adc_chan` at successive sample strobes. A dropped periodic request shows as a missing strobe one period later. A settle counter loaded with the wrong value moves the `adc_sample` pulse by that many cycles, which the per-cycle comparison catches at that strobe. Errors in the source tag or the status logic reach `sw_result`, `auto_result`, `status` and `irq` one cycle after the done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned CH_W  = 4;
  localparam int unsigned IS_W  = 2;
  localparam int unsigned ST_W  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_WAIT   = 2'd2
  } sq_state_e;

  typedef enum logic {
    SRC_SW   = 1'b0,
    SRC_AUTO = 1'b1
  } src_e;

  // Channels usable by the application within the 16-entry space
  function automatic logic chan_ok(input logic [CH_W-1:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd7, 4'd10, 4'd11, 4'd12, 4'd13, 4'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Cycles of a delay given in microseconds, at least one
  function automatic int unsigned us_to_cyc(input int unsigned clk_khz,
                                            input int unsigned us);
    int unsigned c;
    c = (clk_khz * us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_period_timer.sv
module adc_period_timer #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  assign lim  = (period == '0) ? '0 : period - 1'b1;
  assign tick = en && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_req_arb.sv
module adc_req_arb
  import adc_seq_pkg::*;
(
  input  logic            idle,
  input  logic            sw_pend,
  input  logic            auto_pend,
  input  logic [CH_W-1:0] sw_chan,
  input  logic [IS_W-1:0] sw_isrc,
  input  logic [CH_W-1:0] auto_chan,
  input  logic [IS_W-1:0] auto_isrc,
  output logic            grant_sw,
  output logic            grant_auto,
  output logic [CH_W-1:0] sel_chan,
  output logic [IS_W-1:0] sel_isrc,
  output src_e            sel_src,
  output logic            sel_ok
);
  assign grant_sw   = idle && sw_pend;
  assign grant_auto = idle && auto_pend && !sw_pend;

  always_comb begin
    if (sw_pend) begin
      sel_chan = sw_chan;
      sel_isrc = sw_isrc;
      sel_src  = SRC_SW;
    end else begin
      sel_chan = auto_chan;
      sel_isrc = auto_isrc;
      sel_src  = SRC_AUTO;
    end
  end

  assign sel_ok = chan_ok(sel_chan);
endmodule

// File: rtl/adc_settle_ctr.sv
module adc_settle_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_req_seq.sv
module adc_req_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned PW       = 16,
  parameter int unsigned DW       = 12,
  parameter int unsigned CLK_KHZ  = 100,
  parameter int unsigned BASE_US  = 20,
  parameter int unsigned EXT_US   = 400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_req,
  input  logic [3:0]      sw_chan,
  input  logic [1:0]      sw_isrc,
  input  logic            auto_en,
  input  logic [PW-1:0]   auto_period,
  input  logic [3:0]      auto_chan,
  input  logic [1:0]      auto_isrc,
  input  logic            ext_delay,
  input  logic            sw_rd,
  input  logic            auto_rd,
  input  logic            status_wr,
  input  logic [2:0]      status_wdata,
  output logic [3:0]      adc_chan,
  output logic [1:0]      adc_isrc,
  output logic            adc_sample,
  input  logic            adc_done,
  input  logic [DW-1:0]   adc_data,
  output logic [DW-1:0]   sw_result,
  output logic            sw_valid,
  output logic [DW-1:0]   auto_result,
  output logic            auto_valid,
  output logic [2:0]      status,
  output logic            irq
);
  localparam int unsigned BASE_CYC = us_to_cyc(CLK_KHZ, BASE_US);
  localparam int unsigned EXT_CYC  = us_to_cyc(CLK_KHZ, EXT_US);
  localparam int unsigned SCW      = $clog2(BASE_CYC + EXT_CYC + 1);
  localparam logic [SCW-1:0] LOAD_SHORT = SCW'(BASE_CYC - 1);
  localparam logic [SCW-1:0] LOAD_LONG  = SCW'(BASE_CYC + EXT_CYC - 1);

  sq_state_e       state_q;
  logic            sw_pend_q, auto_pend_q;
  logic [CH_W-1:0] sw_chan_q, cur_chan_q;
  logic [IS_W-1:0] sw_isrc_q, cur_isrc_q;
  src_e            cur_src_q;
  logic [DW-1:0]   sw_res_q, auto_res_q;
  logic            sw_val_q, auto_val_q;
  logic [ST_W-1:0] stat_q;

  // Named internal events
  logic            idle, busy, waiting;
  logic            tick;
  logic            grant_sw, grant_auto, grant_any;
  logic [CH_W-1:0] sel_chan;
  logic [IS_W-1:0] sel_isrc;
  src_e            sel_src;
  logic            sel_ok;
  logic            start_evt, reject_evt, sample_evt;
  logic            done_evt, done_sw_evt, done_auto_evt;
  logic            settle_zero;
  logic [ST_W-1:0] stat_set, stat_clr;

  assign idle    = (state_q == SQ_IDLE);
  assign busy    = !idle;
  assign waiting = (state_q == SQ_WAIT);

  adc_period_timer #(.PW(PW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (auto_en),
    .period (auto_period),
    .tick   (tick)
  );

  adc_req_arb u_arb (
    .idle       (idle),
    .sw_pend    (sw_pend_q),
    .auto_pend  (auto_pend_q),
    .sw_chan    (sw_chan_q),
    .sw_isrc    (sw_isrc_q),
    .auto_chan  (auto_chan),
    .auto_isrc  (auto_isrc),
    .grant_sw   (grant_sw),
    .grant_auto (grant_auto),
    .sel_chan   (sel_chan),
    .sel_isrc   (sel_isrc),
    .sel_src    (sel_src),
    .sel_ok     (sel_ok)
  );

  assign grant_any  = grant_sw || grant_auto;
  assign start_evt  = grant_any && sel_ok;
  assign reject_evt = grant_any && !sel_ok;

  adc_settle_ctr #(.CW(SCW)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .load_val (ext_delay ? LOAD_LONG : LOAD_SHORT),
    .dec      (state_q == SQ_SETTLE),
    .zero     (settle_zero)
  );

  assign sample_evt    = (state_q == SQ_SETTLE) && settle_zero;
  assign done_evt      = waiting && adc_done;
  assign done_sw_evt   = done_evt && (cur_src_q == SRC_SW);
  assign done_auto_evt = done_evt && (cur_src_q == SRC_AUTO);

  // Sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cur_chan_q <= '0;
      cur_isrc_q <= '0;
      cur_src_q  <= SRC_SW;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_evt) begin
          state_q    <= SQ_SETTLE;
          cur_chan_q <= sel_chan;
          cur_isrc_q <= sel_isrc;
          cur_src_q  <= sel_src;
        end
        SQ_SETTLE: if (settle_zero) state_q <= SQ_WAIT;
        SQ_WAIT:   if (adc_done)    state_q <= SQ_IDLE;
        default:   state_q <= SQ_IDLE;
      endcase
    end
  end

  // Pending requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend_q   <= 1'b0;
      sw_chan_q   <= '0;
      sw_isrc_q   <= '0;
      auto_pend_q <= 1'b0;
    end else begin
      sw_pend_q   <= sw_req || (sw_pend_q && !grant_sw);
      auto_pend_q <= tick || (auto_pend_q && !grant_auto);
      if (sw_req) begin
        sw_chan_q <= sw_chan;
        sw_isrc_q <= sw_isrc;
      end
    end
  end

  // Result registers and valid flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_res_q   <= '0;
      auto_res_q <= '0;
      sw_val_q   <= 1'b0;
      auto_val_q <= 1'b0;
    end else begin
      if (done_sw_evt)   sw_res_q   <= adc_data;
      if (done_auto_evt) auto_res_q <= adc_data;
      sw_val_q   <= done_sw_evt   || (sw_val_q   && !sw_rd);
      auto_val_q <= done_auto_evt || (auto_val_q && !auto_rd);
    end
  end

  // Status register, clear-on-one writes, set wins
  assign stat_set = {reject_evt, done_auto_evt, done_sw_evt};
  assign stat_clr = status_wr ? status_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  assign adc_chan    = cur_chan_q;
  assign adc_isrc    = (cur_chan_q == '0) ? cur_isrc_q : '0;
  assign adc_sample  = sample_evt;
  assign sw_result   = sw_res_q;
  assign sw_valid    = sw_val_q;
  assign auto_result = auto_res_q;
  assign auto_valid  = auto_val_q;
  assign status      = stat_q;
  assign irq         = |stat_q;

endmodule

// File: rtl/adc_req_seq_chk.sv
module adc_req_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_sample,
  input logic [3:0]    adc_chan,
  input logic          adc_done,
  input logic [DW-1:0] sw_result,
  input logic [DW-1:0] auto_result,
  input logic          sw_valid,
  input logic [2:0]    status,
  input logic          irq,
  input logic          busy,
  input logic          waiting,
  input logic          reject_evt,
  input logic          done_evt,
  input logic          done_sw_evt,
  input logic          grant_auto,
  input logic          sw_pend_q
);
  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sample |=> !adc_sample); // R3
  AST_SAMPLE_CHAN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sample |-> chan_ok(adc_chan)); // R2
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> status[2]); // R2
  AST_REJECT_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> !adc_sample); // R2
  AST_SW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    grant_auto |-> !sw_pend_q); // R1
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(adc_chan)); // R4
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_sw_evt |=> sw_valid); // R5
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq); // R7
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !waiting) |=> ($stable(sw_result) && $stable(auto_result))); // R9
endmodule

bind adc_req_seq adc_req_seq_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_sample  (adc_sample),
  .adc_chan    (adc_chan),
  .adc_done    (adc_done),
  .sw_result   (sw_result),
  .auto_result (auto_result),
  .sw_valid    (sw_valid),
  .status      (status),
  .irq         (irq),
  .busy        (busy),
  .waiting     (waiting),
  .reject_evt  (reject_evt),
  .done_evt    (done_evt),
  .done_sw_evt (done_sw_evt),
  .grant_auto  (grant_auto),
  .sw_pend_q   (sw_pend_q)
);

// File: tb/adc_req_seq_tb_top.sv
module adc_req_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;   // 20 us at 100 kHz
  localparam int EXT  = 40;  // 400 us at 100 kHz
  localparam int LAT  = 3;   // converter latency after strobe
  localparam int WDOG = 50000;

  logic        clk = 0, rst_n = 0;
  logic        sw_req = 0, auto_en = 0, ext_delay = 0, sw_rd = 0, auto_rd = 0, status_wr = 0;
  logic [3:0]  sw_chan = 0, auto_chan = 0;
  logic [1:0]  sw_isrc = 0, auto_isrc = 0;
  logic [15:0] auto_period = 0;
  logic [2:0]  status_wdata = 0;
  logic        adc_done_m = 0, stray_done = 0;
  logic [11:0] adc_data = 0;
  wire         adc_done = adc_done_m | stray_done;
  wire [3:0]   adc_chan;
  wire [1:0]   adc_isrc;
  wire         adc_sample, sw_valid, auto_valid, irq;
  wire [11:0]  sw_result, auto_result;
  wire [2:0]   status;

  int errors = 0, checks = 0, cycles = 0;

  adc_req_seq dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // ---------------- converter model ----------------
  int adc_cnt = -1;
  int conv_no = 0;
  int q_chan[$];
  always @(negedge clk) begin
    adc_done_m <= 0;
    if (adc_cnt == 0) begin
      adc_done_m <= 1;
      adc_data   <= 12'(q_chan[$] * 256 + conv_no);
      adc_cnt    = -1;
    end else if (adc_cnt > 0) adc_cnt--;
    if (adc_sample && rst_n) begin
      q_chan.push_back(int'(adc_chan));
      conv_no++;
      adc_cnt = LAT - 1;
    end
  end

  // ---------------- behavioural reference ----------------
  int   m_phase, m_left, m_src, m_chan, m_isrc, m_age;
  bit   m_swp, m_ap, m_swv, m_auv;
  int   m_swc, m_swi, m_swres, m_aures;
  bit [2:0] m_stat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_src = 0; m_chan = 0; m_isrc = 0; m_age = 0;
      m_swp = 0; m_ap = 0; m_swv = 0; m_auv = 0; m_swc = 0; m_swi = 0;
      m_swres = 0; m_aures = 0; m_stat = 0;
    end else begin
      int per, ch, is, src;
      bit tick, take, ok, fin;
      bit [2:0] set;
      per  = (auto_period == 0) ? 1 : int'(auto_period);
      tick = auto_en && (m_age + 1 >= per);
      take = (m_phase == 0) && (m_swp || m_ap);
      src  = m_swp ? 0 : 1;
      ch   = m_swp ? m_swc : int'(auto_chan);
      is   = m_swp ? m_swi : int'(auto_isrc);
      ok   = ch inside {0, 1, 2, 7, 10, 11, 12, 13, 15};
      fin  = (m_phase == 2) && adc_done;
      set  = 0;
      if (fin && m_src == 0) begin m_swres = int'(adc_data); set[0] = 1; end
      if (fin && m_src == 1) begin m_aures = int'(adc_data); set[1] = 1; end
      m_swv = set[0] || (m_swv && !sw_rd);
      m_auv = set[1] || (m_auv && !auto_rd);
      if (take && !ok) set[2] = 1;
      m_stat = (m_stat & ~(status_wr ? status_wdata : 3'b0)) | set;
      if (m_phase == 1) begin
        if (m_left == 0) m_phase = 2; else m_left--;
      end else if (fin) m_phase = 0;
      else if (take && ok) begin
        m_phase = 1; m_left = (ext_delay ? BASE + EXT : BASE) - 1;
        m_chan = ch; m_isrc = is; m_src = src;
      end
      if (take && src == 0) m_swp = 0;
      if (take && src == 1) m_ap = 0;
      if (sw_req) begin m_swp = 1; m_swc = int'(sw_chan); m_swi = int'(sw_isrc); end
      if (tick) m_ap = 1;
      m_age = (!auto_en || tick) ? 0 : m_age + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit es; int ei;
    es = (m_phase == 1) && (m_left == 0);
    ei = (m_chan == 0) ? m_isrc : 0;
    chk(adc_sample == es, "R3 sample strobe timing", adc_sample, es);
    chk(adc_chan == 4'(m_chan) && adc_isrc == 2'(ei), "R4 channel/current select",
        {adc_chan, adc_isrc}, {4'(m_chan), 2'(ei)});
    chk(sw_result == 12'(m_swres) && auto_result == 12'(m_aures), "R5 result registers",
        {sw_result, auto_result}, {12'(m_swres), 12'(m_aures)});
    chk(sw_valid == m_swv && auto_valid == m_auv, "R6 valid flags",
        {sw_valid, auto_valid}, {m_swv, m_auv});
    chk(status == m_stat && irq == (m_stat != 0), "R7 status/irq",
        {status, irq}, {m_stat, (m_stat != 0)});
  end

  // ---------------- directed stimulus ----------------
  task automatic sw_go(input int ch, input int is, output int lat);
    sw_chan = 4'(ch); sw_isrc = 2'(is); sw_req = 1;
    lat = 0;
    do begin @(negedge clk); sw_req = 0; lat++; end while (!adc_sample && lat < 500);
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all;
    status_wr = 1; status_wdata = 3'b111; sw_rd = 1; auto_rd = 1;
    @(negedge clk);
    status_wr = 0; status_wdata = 0; sw_rd = 0; auto_rd = 0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cycles++;
      if (cycles > WDOG) begin
        chk(0, "watchdog expired", cycles, WDOG);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    int lat, nsamp;
    idle_n(3);
    chk(adc_sample == 0 && irq == 0 && status == 0 && sw_valid == 0 && auto_valid == 0
        && adc_chan == 0, "R10 reset state", {adc_sample, irq, status}, 0);
    rst_n = 1;
    idle_n(2);

    // R3 base delay, R5 result latch
    sw_go(2, 0, lat);
    chk(lat == BASE + 1, "R3 base settle latency", lat, BASE + 1);
    idle_n(LAT + 2);
    chk(sw_valid == 1 && sw_result == 12'(2 * 256 + conv_no), "R5 sw result stored",
        sw_result, 2 * 256 + conv_no);
    chk(status == 3'b001 && irq == 1, "R7 sw done status", status, 1);

    // R6 read clears valid, R7 W1C
    sw_rd = 1; @(negedge clk); sw_rd = 0;
    chk(sw_valid == 0, "R6 read clears valid", sw_valid, 0);
    status_wr = 1; status_wdata = 3'b001; @(negedge clk); status_wr = 0;
    chk(irq == 0 && status == 0, "R7 clear-on-one write", status, 0);

    // R3 extended delay
    ext_delay = 1;
    sw_go(7, 0, lat);
    chk(lat == BASE + EXT + 1, "R3 extended settle latency", lat, BASE + EXT + 1);
    ext_delay = 0;
    idle_n(LAT + 2); clear_all;

    // R4 current select only on channel 0
    sw_go(0, 3, lat);
    chk(adc_isrc == 2'd3, "R4 ch0 current code", adc_isrc, 3);
    idle_n(LAT + 2);
    sw_go(1, 2, lat);
    chk(adc_isrc == 2'd0 && adc_chan == 4'd1, "R4 non-zero channel has no current",
        adc_isrc, 0);
    idle_n(LAT + 2); clear_all;

    // R2 invalid channel rejected
    nsamp = q_chan.size();
    sw_chan = 4'd5; sw_req = 1; @(negedge clk); sw_req = 0;
    idle_n(10);
    chk(q_chan.size() == nsamp, "R2 no strobe for channel 5", q_chan.size(), nsamp);
    chk(status == 3'b100 && irq == 1 && sw_valid == 0, "R2 error flag only",
        status, 4);
    clear_all;

    // R9 stray done while idle
    lat = int'(sw_result);
    adc_data = 12'hABC; stray_done = 1; @(negedge clk); stray_done = 0;
    idle_n(2);
    chk(int'(sw_result) == lat && status == 0 && sw_valid == 0, "R9 stray done ignored",
        sw_result, lat);

    // R1 priority and pending retention, R8 periodic
    q_chan.delete();
    auto_chan = 4'd12; auto_isrc = 0; auto_period = 16'd10; ext_delay = 1;
    sw_chan = 4'd13; sw_req = 1; @(negedge clk); sw_req = 0;
    auto_en = 1;
    idle_n(20);
    ext_delay = 0;
    sw_chan = 4'd11; sw_req = 1; @(negedge clk); sw_req = 0;
    idle_n(60);
    chk(q_chan.size() >= 3, "R1 three conversions ran", q_chan.size(), 3);
    if (q_chan.size() >= 3)
      chk(q_chan[0] == 13 && q_chan[1] == 11 && q_chan[2] == 12, "R1 software before periodic",
          q_chan[1] * 256 + q_chan[2], 11 * 256 + 12);
    chk(auto_valid == 1, "R8 periodic result produced", auto_valid, 1);
    auto_period = 16'd0; idle_n(20);
    auto_en = 0;
    idle_n(15); clear_all;
    nsamp = q_chan.size();
    idle_n(100);
    chk(q_chan.size() == nsamp, "R8 no periodic requests when disabled", q_chan.size(), nsamp);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule